// File: doc/BRIEF.md
# Delayed Implication Assertion Monitor

This block checks one clocked property while the chip runs. The property is: when the trigger input is high in a cycle, the response input must be high in at least one cycle from START to START+LENGTH cycles later. The result is a single `hold_ok_o` bit. It stays high and drops for exactly one cycle, the cycle in which a trigger's window closes without a response. START and LENGTH are elaboration-time parameters. START must be at least 1 and LENGTH must be zero or more; any other pair stops elaboration with an error. A LENGTH of zero gives an exact-delay check. Any larger LENGTH gives a bounded-window check.

Each trigger becomes a pending bit that moves down a chain of single-bit age stages, one stage per cycle. While a pending bit is younger than START cycles, it moves on whatever the response does. From age START onward, a high response removes it, and a low response lets it age by one more stage. A bit that reaches the oldest stage while the response is still low is a violation. Because there is one stage per age, triggers in consecutive cycles are tracked side by side and cleared independently. Every stage powers up at zero, and a synchronous active-high reset also clears the chain.

Top module: `delay_impl_monitor`

## Requirements
- R1: In the cycles after reset and on power-up, `hold_ok_o` is 1. It stays 1 until a trigger sampled after reset has had a full window to expire.
- R2: In any cycle in which `resp_i` is 1, `hold_ok_o` is 1.
- R3: A trigger in cycle t followed by a response in cycle t+START, the earliest cycle of the window, causes no violation.
- R4: A trigger in cycle t followed by a response in cycle t+START+LENGTH, the last cycle of the window, causes no violation.
- R5: A trigger in cycle t with no response anywhere in cycles t+START to t+START+LENGTH drives `hold_ok_o` to 0 in cycle t+START+LENGTH and in no other cycle.
- R6: A response in cycle t or in cycles t+1 to t+START-1 does not satisfy a trigger from cycle t.
- R7: A response in cycle t+START+LENGTH+1 or later comes too late, and the violation of R5 is still reported.
- R8: Triggers in different cycles are tracked independently. A response clears exactly those triggers whose window contains that cycle.
- R9: With LENGTH = 0, `hold_ok_o` is 0 in a cycle exactly when the trigger was 1 START cycles earlier and `resp_i` is 0 now.
- R10: A cycle with `rst` = 1 discards every trigger sampled in that cycle or earlier, so none of them can produce a violation.
- R11: While `trig_i` stays 0, `hold_ok_o` stays 1 for any response pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset; empties the age chain |
| trig_i | input | 1 | Antecedent; a 1 opens a response window |
| resp_i | input | 1 | Consequent; a 1 satisfies every open window that contains this cycle |
| hold_ok_o | output | 1 | 1 when the property holds this cycle, 0 in a violation cycle |

## Verification
Three instances run side by side: a window with START=2 and LENGTH=3, an exact delay with START=1, and a window with START=1. This lets the same stimulus separate the clearing stages from the plain shift stages. Single triggers are answered one cycle before the window, at its first cycle, at its last cycle and one cycle after it. These cases pin down the off-by-one boundaries of R3, R4, R6 and R7. Runs of back-to-back triggers answered by one response show whether requests are cleared independently or as a group. A reset issued while requests are in flight shows that stale requests are dropped. A long random phase is compared against a timestamp-based reference model.

// File: rtl/dim_pkg.sv
package dim_pkg;

    typedef enum logic {
        DIM_EXACT  = 1'b0,
        DIM_WINDOW = 1'b1
    } dim_mode_e;

    typedef struct packed {
        logic trig;
        logic resp;
    } dim_obs_t;

    function automatic bit dim_cfg_ok(input int start_c, input int length_c);
        return (start_c >= 1) && (length_c >= 0);
    endfunction

    function automatic int dim_span(input int start_c, input int length_c);
        return start_c + length_c;
    endfunction

    function automatic dim_mode_e dim_mode_of(input int length_c);
        return (length_c == 0) ? DIM_EXACT : DIM_WINDOW;
    endfunction

    // a stage at this age may be cleared by the response feeding it
    function automatic bit dim_stage_clears(input int age, input int start_c);
        return (age - 1) >= start_c;
    endfunction

endpackage

// File: rtl/dim_age_stage.sv
module dim_age_stage #(
    parameter bit CLEARABLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pend_in,
    input  logic resp,
    output logic pend_q
);

    logic pend_r = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_r <= 1'b0;
        end else if (CLEARABLE) begin
            pend_r <= pend_in & ~resp;
        end else begin
            pend_r <= pend_in;
        end
    end

    assign pend_q = pend_r;

endmodule

// File: rtl/dim_age_chain.sv
module dim_age_chain
    import dim_pkg::*;
#(
    parameter int START  = 2,
    parameter int LENGTH = 3,
    localparam int AGE_MAX = dim_span(START, LENGTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  dim_obs_t       obs,
    output logic [AGE_MAX:1] ages
);

    localparam dim_mode_e MODE = dim_mode_of(LENGTH);

    generate
        if (MODE == DIM_EXACT) begin : g_exact
            // pure delay line: no stage may be cleared
            for (genvar k = 1; k <= AGE_MAX; k++) begin : g_stage
                if (k == 1) begin : g_head
                    dim_age_stage #(.CLEARABLE(1'b0)) u_stage (
                        .clk(clk), .rst(rst), .pend_in(obs.trig),
                        .resp(obs.resp), .pend_q(ages[k])
                    );
                end else begin : g_body
                    dim_age_stage #(.CLEARABLE(1'b0)) u_stage (
                        .clk(clk), .rst(rst), .pend_in(ages[k-1]),
                        .resp(obs.resp), .pend_q(ages[k])
                    );
                end
            end
        end else begin : g_window
            // ages below START pass through; later ages drop on a response
            for (genvar k = 1; k <= AGE_MAX; k++) begin : g_stage
                if (k == 1) begin : g_head
                    dim_age_stage #(.CLEARABLE(1'b0)) u_stage (
                        .clk(clk), .rst(rst), .pend_in(obs.trig),
                        .resp(obs.resp), .pend_q(ages[k])
                    );
                end else begin : g_body
                    dim_age_stage #(.CLEARABLE(dim_stage_clears(k, START))) u_stage (
                        .clk(clk), .rst(rst), .pend_in(ages[k-1]),
                        .resp(obs.resp), .pend_q(ages[k])
                    );
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dim_verdict.sv
module dim_verdict
    import dim_pkg::*;
#(
    parameter int LENGTH = 3
) (
    input  logic oldest,
    input  logic resp,
    output logic ok
);

    localparam dim_mode_e MODE = dim_mode_of(LENGTH);

    generate
        if (MODE == DIM_EXACT) begin : g_exact
            assign ok = ~oldest | resp;
        end else begin : g_window
            logic expired;
            assign expired = oldest & ~resp;
            assign ok = ~expired;
        end
    endgenerate

endmodule

// File: rtl/delay_impl_monitor.sv
module delay_impl_monitor
    import dim_pkg::*;
#(
    parameter int START  = 2,
    parameter int LENGTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic resp_i,
    output logic hold_ok_o
);

    localparam int AGE_MAX = dim_span(START, LENGTH);

    generate
        if (!dim_cfg_ok(START, LENGTH)) begin : g_bad_cfg
            $error("delay_impl_monitor: START must be >= 1 and LENGTH >= 0");
        end
    endgenerate

    dim_obs_t         obs;
    logic [AGE_MAX:1] age_vec;

    assign obs.trig = trig_i;
    assign obs.resp = resp_i;

    dim_age_chain #(
        .START (START),
        .LENGTH(LENGTH)
    ) u_chain (
        .clk (clk),
        .rst (rst),
        .obs (obs),
        .ages(age_vec)
    );

    dim_verdict #(
        .LENGTH(LENGTH)
    ) u_verdict (
        .oldest(age_vec[AGE_MAX]),
        .resp  (resp_i),
        .ok    (hold_ok_o)
    );

endmodule

// File: rtl/delay_impl_monitor_chk.sv
module delay_impl_monitor_chk #(
    parameter int START  = 2,
    parameter int LENGTH = 3,
    localparam int AGE_MAX = START + LENGTH,
    localparam int CW = $clog2(AGE_MAX + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_i,
    input logic             resp_i,
    input logic             hold_ok_o,
    input logic [AGE_MAX:1] age_vec
);

    logic [CW-1:0] since_rst = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != CW'(AGE_MAX)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    assert_fill_ok_R1: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(AGE_MAX)) |-> hold_ok_o);

    assert_resp_ok_R2: assert property (@(posedge clk) disable iff (rst)
        resp_i |-> hold_ok_o);

    assert_fail_source_R5: assert property (@(posedge clk) disable iff (rst)
        !hold_ok_o |-> (age_vec[AGE_MAX] && !resp_i));

    assert_entry_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (age_vec[1] == $past(trig_i)));

    assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (age_vec == '0));

    generate
        for (genvar k = 2; k <= AGE_MAX; k++) begin : g_stage_chk
            if (k - 1 < START) begin : g_young
                // R6: a response at a young age leaves the request in place
                assert_young_pass_R6: assert property (@(posedge clk) disable iff (rst)
                    !$past(rst) |-> (age_vec[k] == $past(age_vec[k-1])));
            end else begin : g_old
                // R8: an old request survives only a silent cycle
                assert_window_clear_R8: assert property (@(posedge clk) disable iff (rst)
                    (!$past(rst) && age_vec[k]) |-> ($past(age_vec[k-1]) && !$past(resp_i)));
            end
        end
    endgenerate

endmodule

bind delay_impl_monitor delay_impl_monitor_chk #(
    .START (START),
    .LENGTH(LENGTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig_i   (trig_i),
    .resp_i   (resp_i),
    .hold_ok_o(hold_ok_o),
    .age_vec  (age_vec)
);

// File: tb/delay_impl_monitor_tb_top.sv
module delay_impl_monitor_tb_top;

    localparam int HIST = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic resp = 1'b0;
    logic ok_i, ok_x, ok_w;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit ah[HIST];
    bit ch[HIST];
    bit rh[HIST];

    always #5 clk = ~clk;

    // window START=2 LENGTH=3
    delay_impl_monitor #(.START(2), .LENGTH(3)) dut_i (
        .clk(clk), .rst(rst), .trig_i(trig), .resp_i(resp), .hold_ok_o(ok_i));
    // exact START=1
    delay_impl_monitor #(.START(1), .LENGTH(0)) dut_x (
        .clk(clk), .rst(rst), .trig_i(trig), .resp_i(resp), .hold_ok_o(ok_x));
    // window START=1 LENGTH=2
    delay_impl_monitor #(.START(1), .LENGTH(2)) dut_w (
        .clk(clk), .rst(rst), .trig_i(trig), .resp_i(resp), .hold_ok_o(ok_w));

    // reference: trigger at j=m-end must see a response in [j+s, m] unless reset in [j, m-1]
    function automatic bit model_ok(int m, int s, int l);
        int j;
        j = m - (s + l);
        if (j < 0) return 1'b1;
        if (!ah[j]) return 1'b1;
        for (int r = j; r < m; r++) if (rh[r]) return 1'b1;
        for (int q = j + s; q <= m; q++) if (ch[q]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag, input string who);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s cycle %0d: hold_ok_o=%b expected %b", tag, who, cyc, got, exp);
        end
    endtask

    task automatic step(input logic a, input logic c, input logic r, input string tag);
        @(negedge clk);
        trig = a; resp = c; rst = r;
        ah[cyc] = a; ch[cyc] = c; rh[cyc] = r;
        #1;
        chk(ok_i, model_ok(cyc, 2, 3), tag, "dut_i");
        chk(ok_x, model_ok(cyc, 1, 0), tag, "dut_x");
        chk(ok_w, model_ok(cyc, 1, 2), tag, "dut_w");
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
    endtask

    // trigger once, answer at offset d (negative: no answer)
    task automatic one_shot(input int d, input string tag);
        step(1'b1, d == 0, 1'b0, tag);
        for (int i = 1; i <= 8; i++) step(1'b0, i == d, 1'b0, tag);
    endtask

    task automatic t_reset_R1;
        step(1'b0, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
        idle(8, "R1");
    endtask

    task automatic t_resp_R2;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b0, "R2");
        idle(7, "R2");
    endtask

    task automatic t_lower_edge_R3;
        one_shot(1, "R3");
        one_shot(2, "R3");
    endtask

    task automatic t_upper_edge_R4;
        one_shot(3, "R4");
        one_shot(5, "R4");
    endtask

    task automatic t_miss_R5;
        one_shot(-1, "R5");
    endtask

    task automatic t_early_R6;
        one_shot(0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, 1'b0, "R6");
        idle(7, "R6");
    endtask

    task automatic t_late_R7;
        one_shot(4, "R7");
        one_shot(6, "R7");
    endtask

    task automatic t_b2b_R8;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R8");
        idle(8, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R8");
        idle(8, "R8");
    endtask

    task automatic t_exact_R9;
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b0, "R9");
        idle(8, "R9");
    endtask

    task automatic t_reset_mid_R10;
        step(1'b1, 1'b0, 1'b0, "R10");
        step(1'b1, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b1, "R10");
        idle(8, "R10");
    endtask

    task automatic t_idle_R11;
        for (int i = 0; i < 20; i++) step(1'b0, (i % 3) == 1, 1'b0, "R11");
    endtask

    task automatic t_random_R8;
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) == 0, ($urandom % 3) == 0, 1'b0, "R8");
        idle(8, "R8");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_R1();
        t_resp_R2();
        t_lower_edge_R3();
        t_upper_edge_R4();
        t_miss_R5();
        t_early_R6();
        t_late_R7();
        t_b2b_R8();
        t_exact_R9();
        t_reset_mid_R10();
        t_idle_R11();
        t_random_R8();
        summary();
        $finish;
    end

endmodule